// File: doc/BRIEF.md
# Page Write Buffer with Quarter-Array Write Protection

This block sits between the serial command sequencer of a byte-wide serial memory and its storage array. Each data byte that the sequencer delivers during a write command is held in a 64-slot page buffer. It is not written to the array straight away. The slot is picked by the low six bits of the byte's address. The page, which is the upper address bits, is taken from the first data byte of the command. When the bus STOP event arrives and at least one byte was loaded, the block runs one timed write cycle. During that cycle it keeps busy high and writes every loaded slot to the array.

A write-protect input guards one quarter of the address space. A parameter picks the bottom quarter or the top quarter. When protection is active and the first data byte of a command falls in the guarded quarter, the block refuses that byte. It also refuses every later byte of the same command, and nothing is programmed. While busy is high, the block ignores all bytes and STOP events. A combinational read port gives the sequencer's read path the current content of the array. The array is a behavioural register file with 2^ADDR_W bytes. Setting ADDR_W = 13 gives 8192 bytes.

Top module: `pwb_top`

## Requirements
- R1: After reset, busy_o, ack_o and mem_we_o are 0 and every array byte reads 8'hFF.
- R2: A data byte strobed while idle and not refused gives ack_o = 1 in the strobe cycle. The byte is buffered only, so the array location still reads its old value until the write cycle.
- R3: A STOP sampled while idle, after at least one accepted byte, sets busy_o from the next cycle for exactly max(WR_CYCLES, 64) cycles. By the time busy_o falls, every accepted byte is in the array at {page of first byte, slot}.
- R4: A STOP with no accepted byte since the previous STOP or reset (a dummy write) starts no write cycle, and busy_o stays 0.
- R5: The slot is address bits [5:0]. When more than 64 bytes arrive before the STOP, a later byte to the same slot replaces the earlier one, and only the last value is programmed.
- R6: Only slots loaded in the current command are written. Other bytes of the same page keep their old values.
- R7: While busy_o is 1, data bytes get ack_o = 0 and are not buffered, and STOP is ignored.
- R8: With wp_i = 1, a first data byte whose address bits [ADDR_W-1:ADDR_W-2] are 2'b00 (PROT_TOP = 0; 2'b11 when PROT_TOP = 1) gets ack_o = 0. All later bytes of that command also get ack_o = 0, nothing is programmed, and the STOP starts no cycle.
- R9: With wp_i = 0, every address, including the guarded quarter, is accepted and programmed.
- R10: With wp_i = 1, addresses outside the guarded quarter are accepted and programmed, including the first address after the quarter boundary.
- R11: rd_data_o always shows the array byte at rd_addr_i, combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | One-cycle strobe for a received data byte |
| byte_i | input | 8 | Data byte |
| addr_i | input | ADDR_W | Array address for this byte, from the address pointer |
| stop_i | input | 1 | One-cycle STOP event from the bus front end |
| wp_i | input | 1 | Write-protect input |
| rd_addr_i | input | ADDR_W | Read address |
| ack_o | output | 1 | Acknowledge decision for the byte strobed this cycle |
| busy_o | output | 1 | Write cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | 8 | Array write data |
| rd_data_o | output | 8 | Array byte at rd_addr_i |

## Verification
The assertions assume that byte_vld_i and stop_i are single-cycle strobes that are never high in the same cycle. They also assume that wp_i and addr_i are steady during each strobe, and that the sequencer keeps the page bits of addr_i fixed within one command. The bench drives every input on the falling clock edge and keeps one idle cycle between events, so these assumptions hold. It sends bytes during a write cycle only to check that they are ignored. It reads the array only through rd_addr_i and rd_data_o.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned PAGE_BYTES = 64;
  localparam int unsigned SLOT_W     = $clog2(PAGE_BYTES);
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf
  import pwb_pkg::*;
#(
  parameter int unsigned PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              first_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PAGE_W-1:0] page_i,
  input  byte_t             data_i,
  input  logic              clr_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [PAGE_BYTES-1:0] mask_o,
  output logic [PAGE_W-1:0] page_o,
  output byte_t             rd_data_o
);
  byte_t slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic [PAGE_W-1:0]     page_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
        mask_q[g] <= 1'b0;
      end else if (clr_i) begin
        mask_q[g] <= 1'b0;
      end else if (load_i && slot_i == SLOT_W'(g)) begin
        slot_q[g] <= data_i;
        mask_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                page_q <= '0;
    else if (load_i && first_i) page_q <= page_i;
  end

  assign mask_o    = mask_q;
  assign page_o    = page_q;
  assign rd_data_o = slot_q[rd_slot_i];
endmodule

// File: rtl/pwb_commit.sv
module pwb_commit
  import pwb_pkg::*;
#(
  parameter int unsigned TOTAL = 64
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [PAGE_BYTES-1:0] mask_i,
  output logic                  busy_o,
  output logic                  we_o,
  output logic [SLOT_W-1:0]     slot_o,
  output logic                  done_o
);
  localparam int unsigned CNT_W = $clog2(TOTAL + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;
  logic             in_page;

  assign last    = busy_q && cnt_q == CNT_W'(TOTAL - 1);
  assign in_page = cnt_q < CNT_W'(PAGE_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (last) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign slot_o = cnt_q[SLOT_W-1:0];
  assign we_o   = busy_q && in_page && mask_i[slot_o];
  assign busy_o = busy_q;
  assign done_o = last;
endmodule

// File: rtl/pwb_store.sv
module pwb_store
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  byte_t             wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output byte_t             rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  byte_t mem_q [DEPTH];

  // erased state after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/pwb_top.sv
module pwb_top
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned WR_CYCLES = 1000000,
  parameter bit          PROT_TOP  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              ack_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic [7:0]        rd_data_o
);
  localparam int unsigned PAGE_W = ADDR_W - SLOT_W;
  localparam int unsigned TOTAL  = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES;

  logic                  first_q, blocked_q;
  logic                  busy, hit_prot, refuse, accept, start, done;
  logic                  cwe;
  logic [SLOT_W-1:0]     cslot;
  logic [PAGE_BYTES-1:0] buf_mask;
  logic [PAGE_W-1:0]     buf_page;
  byte_t                 buf_rd;
  logic [1:0]            quarter;

  assign quarter  = addr_i[ADDR_W-1 -: 2];
  assign hit_prot = wp_i && (PROT_TOP ? (quarter == 2'b11) : (quarter == 2'b00));
  // decision of the first byte sticks for the whole command
  assign refuse   = first_q ? hit_prot : blocked_q;
  assign accept   = byte_vld_i && !busy && !refuse;
  assign start    = stop_i && !busy && (|buf_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q   <= 1'b1;
      blocked_q <= 1'b0;
    end else if (!busy) begin
      if (stop_i) begin
        first_q   <= 1'b1;
        blocked_q <= 1'b0;
      end else if (byte_vld_i) begin
        first_q <= 1'b0;
        if (first_q) blocked_q <= hit_prot;
      end
    end
  end

  pwb_page_buf #(.PAGE_W(PAGE_W)) i_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .first_i   (first_q),
    .slot_i    (addr_i[SLOT_W-1:0]),
    .page_i    (addr_i[ADDR_W-1:SLOT_W]),
    .data_i    (byte_i),
    .clr_i     (done),
    .rd_slot_i (cslot),
    .mask_o    (buf_mask),
    .page_o    (buf_page),
    .rd_data_o (buf_rd)
  );

  pwb_commit #(.TOTAL(TOTAL)) i_commit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .mask_i  (buf_mask),
    .busy_o  (busy),
    .we_o    (cwe),
    .slot_o  (cslot),
    .done_o  (done)
  );

  pwb_store #(.ADDR_W(ADDR_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cwe),
    .waddr_i ({buf_page, cslot}),
    .wdata_i (buf_rd),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  assign ack_o      = accept;
  assign busy_o     = busy;
  assign mem_we_o   = cwe;
  assign mem_addr_o = {buf_page, cslot};
  assign mem_data_o = buf_rd;
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned TOTAL    = 64,
  parameter bit          PROT_TOP = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_vld_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              stop_i,
  input logic              wp_i,
  input logic              ack_o,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              first_i,
  input logic              has_data_i
);
  localparam int unsigned RUN_W = $clog2(TOTAL + 2);

  logic [RUN_W-1:0] run_q;
  logic             in_quarter;

  assign in_quarter = PROT_TOP ? (&addr_i[ADDR_W-1 -: 2]) : (~|addr_i[ADDR_W-1 -: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_ni) AST_BUSY_BOUNDED: assert (run_q <= RUN_W'(TOTAL)); // R3
  end

  AST_ACK_NEEDS_IDLE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (byte_vld_i && !busy_o)); // R7
  AST_WE_INSIDE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o); // R2
  AST_CYCLE_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i)); // R3
  AST_ONE_PAGE_PER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> $stable(mem_addr_o[ADDR_W-1:6])); // R3
  AST_DUMMY_NO_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && !has_data_i) |=> !busy_o); // R4
  AST_PROT_FIRST_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && first_i && wp_i && in_quarter) |-> !ack_o); // R8
endmodule

bind pwb_top pwb_chk #(.ADDR_W(ADDR_W), .TOTAL(TOTAL), .PROT_TOP(PROT_TOP)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .byte_vld_i (byte_vld_i),
  .addr_i     (addr_i),
  .stop_i     (stop_i),
  .wp_i       (wp_i),
  .ack_o      (ack_o),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .first_i    (first_q),
  .has_data_i (|buf_mask)
);

// File: tb/test_pwb_top.sv
`timescale 1ns/1ps
module test_pwb_top;
  localparam int unsigned AW  = 11;
  localparam int unsigned CYC = 70;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bv = 1'b0, stp = 1'b0, wp = 1'b0;
  logic [7:0]    bd = '0;
  logic [AW-1:0] ba = '0, ra = '0;
  logic          ack, busy, we;
  logic [AW-1:0] wa;
  logic [7:0]    wd, rd;

  int n_vec = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwb_top #(.ADDR_W(AW), .WR_CYCLES(CYC), .PROT_TOP(1'b0)) i_pwb_top (
    .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(bv), .byte_i(bd), .addr_i(ba),
    .stop_i(stp), .wp_i(wp), .rd_addr_i(ra), .ack_o(ack), .busy_o(busy),
    .mem_we_o(we), .mem_addr_o(wa), .mem_data_o(wd), .rd_data_o(rd)
  );

  typedef struct packed {
    logic          wp;
    logic [AW-1:0] addr;
    logic [7:0]    data;
    logic          ack;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 11'h010, 8'hA5, 1'b1},  // R9 guarded quarter, wp low
    '{1'b1, 11'h020, 8'h3C, 1'b0},  // R8
    '{1'b1, 11'h400, 8'h5A, 1'b1},  // R10
    '{1'b1, 11'h7FF, 8'hC3, 1'b1},  // R10 top end
    '{1'b1, 11'h1FF, 8'h99, 1'b0},  // R8 last guarded byte
    '{1'b1, 11'h200, 8'h66, 1'b1},  // R10 first unguarded byte
    '{1'b0, 11'h1C0, 8'h11, 1'b1}   // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [AW-1:0] a, input logic [7:0] d,
                          input logic exp_ack, input string req);
    @(negedge clk);
    bv = 1'b1; ba = a; bd = d;
    #1 chk(req, 32'(ack), 32'(exp_ack));
    @(negedge clk);
    bv = 1'b0;
  endtask

  task automatic put_stop();
    @(negedge clk);
    stp = 1'b1;
    @(negedge clk);
    stp = 1'b0;
  endtask

  // counts busy cycles seen at falling edges after the stop
  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 10 * CYC) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    ra = a;
    #1 chk(req, 32'(rd), 32'(exp));
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 ack", 32'(ack), 0);
    chk("R1 we", 32'(we), 0);
    rd_chk(11'h123, 8'hFF, "R1 erased");
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: one-byte commands
    foreach (VECS[i]) begin
      wp = VECS[i].wp;
      put_byte(VECS[i].addr, VECS[i].data, VECS[i].ack, "R8/R9/R10 ack");
      put_stop();
      chk("R3/R8 busy after stop", 32'(busy), 32'(VECS[i].ack));
      wait_idle(n);
      wp = 1'b0;
      rd_chk(VECS[i].addr, VECS[i].ack ? VECS[i].data : 8'hFF, "R8/R9/R10 content");
    end

    // R2 buffered only, R3 cycle length and programming
    put_byte(11'h300, 8'h77, 1'b1, "R2 ack");
    rd_chk(11'h300, 8'hFF, "R2 not yet written");
    put_stop();
    chk("R3 busy", 32'(busy), 1);
    wait_idle(n);
    chk("R3 cycle length", 32'(n), CYC);
    rd_chk(11'h300, 8'h77, "R3 programmed");
    rd_chk(11'h300, 8'h77, "R11 read port");

    // R6 untouched slots keep old data
    put_byte(11'h545, 8'hEE, 1'b1, "R6 setup");
    put_stop(); wait_idle(n);
    for (int k = 0; k < 3; k++) put_byte(11'h540 + AW'(k), 8'h20 + 8'(k), 1'b1, "R6 ack");
    put_stop(); wait_idle(n);
    rd_chk(11'h540, 8'h20, "R6 slot0");
    rd_chk(11'h542, 8'h22, "R6 slot2");
    rd_chk(11'h545, 8'hEE, "R6 old kept");
    rd_chk(11'h543, 8'hFF, "R6 unloaded");

    // R5 wrap inside page
    for (int k = 0; k < 66; k++) put_byte(11'h600 | AW'(k % 64), 8'(k), 1'b1, "R5 ack");
    put_stop(); wait_idle(n);
    chk("R5 length", 32'(n), CYC);
    rd_chk(11'h600, 8'd64, "R5 slot0 overwritten");
    rd_chk(11'h601, 8'd65, "R5 slot1 overwritten");
    rd_chk(11'h602, 8'd2, "R5 slot2");
    rd_chk(11'h63F, 8'd63, "R5 slot63");

    // R4 dummy write
    put_stop();
    chk("R4 no cycle", 32'(busy), 0);
    repeat (3) @(negedge clk);
    chk("R4 still idle", 32'(busy), 0);

    // R7 requests during busy
    put_byte(11'h700, 8'h01, 1'b1, "R7 setup");
    put_stop();
    put_byte(11'h710, 8'h42, 1'b0, "R7 nack busy");
    put_stop();
    wait_idle(n);
    rd_chk(11'h710, 8'hFF, "R7 byte ignored");
    put_stop();
    chk("R7 no leftover cycle", 32'(busy), 0);

    // R8 later bytes of a refused command
    wp = 1'b1;
    put_byte(11'h050, 8'hAB, 1'b0, "R8 first nack");
    put_byte(11'h051, 8'hAC, 1'b0, "R8 later nack");
    put_stop();
    chk("R8 no cycle", 32'(busy), 0);
    wp = 1'b0;
    rd_chk(11'h051, 8'hFF, "R8 not programmed");

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule